// File: doc/BRIEF.md
# PWM Script Loader and Launcher

This block holds the instruction store for three PWM engines and controls when each engine runs. A host sends it short byte commands. A write command carries an address byte and then a 16-bit word, high byte first, and places that word into a 256-entry script memory. A launch command selects an engine and gives it a starting slot. A halt command selects an engine and stops it. The engines fetch their instructions through a separate synchronous read port. How the engines execute those instructions is not part of this block.

Every command byte that selects an engine uses the same layout. Bits 1:0 carry the engine select, where values 1, 2 and 3 name engines 0, 1 and 2 and value 0 is illegal. Bits 7:2 carry a slot number, and the largest legal slot is 59. A byte that breaks one of these rules raises a one-cycle parameter-error pulse, and the rest of that command is dropped. When an engine reports that its script has ended, the block clears that engine's run flag and sets a sticky end flag. These end flags sit at interrupt-status bits 5, 6 and 7, one per engine.

The command decoder is a state machine with these states:
- `ST_IDLE`: waiting for an opcode.
- `ST_ADDR`: expecting the address byte of a write.
- `ST_HI`: expecting the high data byte.
- `ST_LO`: expecting the low data byte.
- `ST_LAUNCH`: expecting the launch byte.
- `ST_HALT`: expecting the halt byte.

It has these transitions:
- From any state, a byte marked first goes to `ST_ADDR`, `ST_LAUNCH` or `ST_HALT` according to its opcode. An unknown opcode goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_HI` if the address byte is valid, and to `ST_IDLE` with an error if it is not.
- `ST_HI` goes to `ST_LO`.
- `ST_LO` goes to `ST_IDLE`.
- `ST_LAUNCH` goes to `ST_IDLE`.
- `ST_HALT` goes to `ST_IDLE`.
- `ST_IDLE` stays in `ST_IDLE` on a byte that is not marked first.

Top module: `pwm_script_loader`

## Requirements
- R1: While reset is active, and afterwards until a command arrives, `run`, `end_irq`, `start_addr` and `bad_param` are all zero.
- R2: Write sequence. A byte marked first with value 0x01 starts the sequence. The next three unmarked bytes are the address byte A, then H, then L. The word at index A becomes {H,L}, and it can be read on `rd_data` one cycle after `rd_addr` is set to A.
- R3: An accepted address byte clears its word at once. If the command is cut short by a new first byte, the word reads 0 when only the address was sent, and {H,8'h00} when the high byte was also sent.
- R4: An address byte with bits 1:0 equal to 0, or with bits 7:2 greater than 59, is rejected. `bad_param` is 1 for exactly the cycle after that byte. Memory is left unchanged, and all following unmarked bytes are ignored.
- R5: Launch sequence. A byte marked first with value 0x02 is followed by one byte V. For a valid V, engine V[1:0]-1 has its run flag set and its `start_addr` field (bits 6n+5:6n) set to V[7:2], both visible the cycle after V. If the engine is already running, it restarts at the new slot.
- R6: A launch byte is checked in the same way as an address byte. A rejected launch byte pulses `bad_param` and changes no run flag and no start address.
- R7: Halt sequence. A byte marked first with value 0x03 is followed by one byte V. If V[1:0] is not 0, engine V[1:0]-1 stops on the next cycle, whatever bits 7:2 hold. If V[1:0] is 0, `bad_param` pulses and no run flag changes.
- R8: A pulse on `eng_done[n]` clears `run[n]` and sets `end_irq[n]` on the next cycle. This still happens when a halt of the same engine arrives in the same cycle. `irq_ack` clears all end flags, but a simultaneous `eng_done` bit wins for its own engine.
- R9: A byte marked first always starts a new command. After an unknown opcode, unmarked bytes have no effect on memory, on the run flags or on `bad_param`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_valid | input | 1 | Command byte present this cycle |
| byte_first | input | 1 | The present byte is an opcode |
| byte_data | input | 8 | Command byte |
| eng_done | input | 3 | Per-engine end-of-script pulse |
| irq_ack | input | 1 | Clears all end flags |
| rd_addr | input | 8 | Engine fetch address |
| rd_data | output | 16 | Script word, one cycle after rd_addr |
| run | output | 3 | Per-engine run flag |
| start_addr | output | 18 | Per-engine start slot, 6 bits each |
| end_irq | output | 3 | Sticky end flags (interrupt-status bits 7:5) |
| bad_param | output | 1 | One-cycle parameter-error pulse |

## Verification
A decoder left in the wrong state shows up at the ports within a single command. A leftover `ST_HI` or `ST_LO` state corrupts the word that the next write targets, which the following read-back reveals. A `ST_IDLE` state reached too early shows up as a missing run flag or a missing error pulse on the cycle after the final byte. Wrong run or start-slot state is visible on `run` and `start_addr` one cycle after each launch or halt. The sweeps cover every possible launch, halt and address byte, so any bound or select decode that is off by one fails at the exact value where it goes wrong.

// File: rtl/pwm_ldr_pkg.sv
package pwm_ldr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HI,
        ST_LO,
        ST_LAUNCH,
        ST_HALT
    } ldr_state_e;

    // engine select field must be non-zero
    function automatic logic sel_ok(input logic [7:0] b);
        return b[1:0] != 2'b00;
    endfunction

    // select non-zero and slot inside the legal range
    function automatic logic slot_ok(input logic [7:0] b, input int unsigned lim);
        return (b[1:0] != 2'b00) && (32'(b[7:2]) <= lim);
    endfunction

endpackage

// File: rtl/pwm_script_ram.sv
module pwm_script_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic [1:0]        wr_be,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_be[1]) mem[wr_addr][DATA_W-1:HALF_W] <= wr_data[DATA_W-1:HALF_W];
        if (wr_be[0]) mem[wr_addr][HALF_W-1:0]      <= wr_data[HALF_W-1:0];
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/pwm_cmd_fsm.sv
module pwm_cmd_fsm
    import pwm_ldr_pkg::*;
#(
    parameter logic [7:0]  OP_WRITE  = 8'h01,
    parameter logic [7:0]  OP_LAUNCH = 8'h02,
    parameter logic [7:0]  OP_HALT   = 8'h03,
    parameter int unsigned MAX_SLOT  = 59
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_valid,
    input  logic        byte_first,
    input  logic [7:0]  byte_data,
    output logic [1:0]  wr_be,
    output logic [7:0]  wr_addr,
    output logic [15:0] wr_data,
    output logic        launch_go,
    output logic        halt_go,
    output logic [1:0]  cmd_sel,
    output logic [5:0]  cmd_slot,
    output logic        cmd_bad
);
    ldr_state_e state, state_nx;
    logic [7:0] ptr;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (byte_valid) begin
            if (byte_first) begin
                if (byte_data == OP_WRITE)       state_nx = ST_ADDR;
                else if (byte_data == OP_LAUNCH) state_nx = ST_LAUNCH;
                else if (byte_data == OP_HALT)   state_nx = ST_HALT;
                else                             state_nx = ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE:   state_nx = ST_IDLE;
                    ST_ADDR:   state_nx = slot_ok(byte_data, MAX_SLOT) ? ST_HI : ST_IDLE;
                    ST_HI:     state_nx = ST_LO;
                    ST_LO:     state_nx = ST_IDLE;
                    ST_LAUNCH: state_nx = ST_IDLE;
                    ST_HALT:   state_nx = ST_IDLE;
                    default:   state_nx = ST_IDLE;
                endcase
            end
        end
    end

    // state register and held word pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ptr   <= '0;
        end else begin
            state <= state_nx;
            if (byte_valid && !byte_first && state == ST_ADDR) ptr <= byte_data;
        end
    end

    // outputs
    always_comb begin
        wr_be     = 2'b00;
        wr_addr   = ptr;
        wr_data   = '0;
        launch_go = 1'b0;
        halt_go   = 1'b0;
        cmd_bad   = 1'b0;
        cmd_sel   = byte_data[1:0];
        cmd_slot  = byte_data[7:2];
        if (byte_valid && !byte_first) begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    wr_addr = byte_data;
                    if (slot_ok(byte_data, MAX_SLOT)) wr_be = 2'b11;
                    else                              cmd_bad = 1'b1;
                end
                ST_HI: begin
                    wr_be   = 2'b10;
                    wr_data = {byte_data, 8'h00};
                end
                ST_LO: begin
                    wr_be   = 2'b01;
                    wr_data = {8'h00, byte_data};
                end
                ST_LAUNCH: begin
                    if (slot_ok(byte_data, MAX_SLOT)) launch_go = 1'b1;
                    else                              cmd_bad   = 1'b1;
                end
                ST_HALT: begin
                    if (sel_ok(byte_data)) halt_go = 1'b1;
                    else                   cmd_bad = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwm_eng_ctl.sv
module pwm_eng_ctl #(
    parameter int NUM_ENG = 3,
    parameter int SLOT_W  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      launch_go,
    input  logic                      halt_go,
    input  logic [1:0]                cmd_sel,
    input  logic [SLOT_W-1:0]         cmd_slot,
    input  logic                      cmd_bad,
    input  logic [NUM_ENG-1:0]        eng_done,
    input  logic                      irq_ack,
    output logic [NUM_ENG-1:0]        run,
    output logic [NUM_ENG*SLOT_W-1:0] start_addr,
    output logic [NUM_ENG-1:0]        end_irq,
    output logic                      bad_param
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bad_param <= 1'b0;
        else        bad_param <= cmd_bad;
    end

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
        logic hit;
        assign hit = (int'(cmd_sel) == g + 1);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run[g]                       <= 1'b0;
                start_addr[g*SLOT_W +: SLOT_W] <= '0;
                end_irq[g]                   <= 1'b0;
            end else begin
                if (launch_go && hit) begin
                    run[g]                       <= 1'b1;
                    start_addr[g*SLOT_W +: SLOT_W] <= cmd_slot;
                end else if ((halt_go && hit) || eng_done[g]) begin
                    run[g] <= 1'b0;
                end
                if (eng_done[g])  end_irq[g] <= 1'b1;
                else if (irq_ack) end_irq[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pwm_script_loader.sv
module pwm_script_loader #(
    parameter int          NUM_ENG   = 3,
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 16,
    parameter int          SLOT_W    = 6,
    parameter int unsigned MAX_SLOT  = 59,
    parameter logic [7:0]  OP_WRITE  = 8'h01,
    parameter logic [7:0]  OP_LAUNCH = 8'h02,
    parameter logic [7:0]  OP_HALT   = 8'h03
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      byte_valid,
    input  logic                      byte_first,
    input  logic [7:0]                byte_data,
    input  logic [NUM_ENG-1:0]        eng_done,
    input  logic                      irq_ack,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    output logic [NUM_ENG-1:0]        run,
    output logic [NUM_ENG*SLOT_W-1:0] start_addr,
    output logic [NUM_ENG-1:0]        end_irq,
    output logic                      bad_param
);
    logic [1:0]        wr_be;
    logic [7:0]        wr_addr;
    logic [15:0]       wr_data;
    logic              launch_go, halt_go, cmd_bad;
    logic [1:0]        cmd_sel;
    logic [5:0]        cmd_slot;

    pwm_cmd_fsm #(
        .OP_WRITE(OP_WRITE), .OP_LAUNCH(OP_LAUNCH), .OP_HALT(OP_HALT), .MAX_SLOT(MAX_SLOT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .byte_valid(byte_valid), .byte_first(byte_first), .byte_data(byte_data),
        .wr_be(wr_be), .wr_addr(wr_addr), .wr_data(wr_data),
        .launch_go(launch_go), .halt_go(halt_go),
        .cmd_sel(cmd_sel), .cmd_slot(cmd_slot), .cmd_bad(cmd_bad)
    );

    pwm_script_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk(clk), .wr_be(wr_be), .wr_addr(wr_addr[ADDR_W-1:0]),
        .wr_data(wr_data[DATA_W-1:0]), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    pwm_eng_ctl #(.NUM_ENG(NUM_ENG), .SLOT_W(SLOT_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .launch_go(launch_go), .halt_go(halt_go), .cmd_sel(cmd_sel),
        .cmd_slot(cmd_slot[SLOT_W-1:0]), .cmd_bad(cmd_bad),
        .eng_done(eng_done), .irq_ack(irq_ack),
        .run(run), .start_addr(start_addr), .end_irq(end_irq), .bad_param(bad_param)
    );
endmodule

// File: rtl/pwm_ldr_chk.sv
module pwm_ldr_chk #(
    parameter int NUM_ENG = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               byte_valid,
    input logic               bad_param,
    input logic [NUM_ENG-1:0] run,
    input logic [NUM_ENG-1:0] eng_done,
    input logic [NUM_ENG-1:0] end_irq
);
    assert_err_from_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_param |-> $past(byte_valid));

    assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_param |=> !bad_param);

    assert_run_rise_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((run & ~$past(run)) != '0) |-> $past(byte_valid));

    assert_done_sets_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done != '0) |=> ((end_irq & $past(eng_done)) == $past(eng_done)));

    assert_done_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done != '0 && !byte_valid) |=> ((run & $past(eng_done)) == '0));
endmodule

bind pwm_script_loader pwm_ldr_chk #(.NUM_ENG(NUM_ENG)) u_chk (.*);

// File: tb/tb_pwm_script_loader.sv
module tb_pwm_script_loader;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic        byte_first = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [2:0]  eng_done = '0;
    logic        irq_ack = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [2:0]  run;
    logic [17:0] start_addr;
    logic [2:0]  end_irq;
    logic        bad_param;

    int checks = 0;
    int errors = 0;

    logic [2:0]  exp_run;
    logic [17:0] exp_sa;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_script_loader dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic f, input logic [7:0] d);
        @(negedge clk);
        byte_valid = 1'b1; byte_first = f; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0; byte_first = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    function automatic logic [15:0] wdat(input logic [7:0] a);
        return {a ^ 8'h5A, ~a};
    endfunction

    function automatic logic good(input logic [7:0] v);
        return (v[1:0] != 0) && (v[7:2] <= 6'd59);
    endfunction

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 run", run, 0);
        chk("R1 end_irq", end_irq, 0);
        chk("R1 start_addr", start_addr, 0);
        chk("R1 bad_param", bad_param, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 run after release", run, 0);
        chk("R1 bad after release", bad_param, 0);

        // R2 / R4: every address byte
        for (int a = 0; a < 256; a++) begin
            logic [15:0] w;
            w = wdat(8'(a));
            send(1, 8'h01);
            send(0, 8'(a));
            chk($sformatf("R4 addr err %0h", a), bad_param, !good(8'(a)));
            if (good(8'(a))) begin
                send(0, w[15:8]);
                send(0, w[7:0]);
            end
        end
        for (int a = 0; a < 256; a++) begin
            if (good(8'(a))) begin
                rd(8'(a), d);
                chk($sformatf("R2 word %0h", a), d, wdat(8'(a)));
            end
        end

        // R4: rejected address ignores following bytes
        send(1, 8'h01);
        send(0, 8'hF1);
        chk("R4 slot 60 err", bad_param, 1);
        send(0, 8'h05);
        chk("R4 follow-on no err", bad_param, 0);
        send(0, 8'h99);
        send(0, 8'h11);
        rd(8'h05, d);
        chk("R4 word unchanged", d, wdat(8'h05));

        // R3: cleared word on truncated commands
        send(1, 8'h01); send(0, 8'h05); send(1, 8'h00);
        rd(8'h05, d);
        chk("R3 addr only clears", d, 16'h0000);
        send(1, 8'h01); send(0, 8'h06); send(0, 8'h77); send(1, 8'h00);
        rd(8'h06, d);
        chk("R3 high only", d, 16'h7700);

        // R5 / R6: every launch byte, engines left running (restart)
        exp_run = '0; exp_sa = '0;
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = 8'(v);
            send(1, 8'h02);
            send(0, b);
            if (good(b)) begin
                exp_run[b[1:0]-1] = 1'b1;
                exp_sa[6*(b[1:0]-1) +: 6] = b[7:2];
            end
            chk($sformatf("R6 launch err %0h", v), bad_param, !good(b));
            chk($sformatf("R5 run %0h", v), run, exp_run);
            chk($sformatf("R5 start_addr %0h", v), start_addr, exp_sa);
        end

        // R7: every halt byte, preceded by a launch
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b, lb;
            b  = 8'(v);
            lb = {6'(v % 60), 2'(v % 3 + 1)};
            send(1, 8'h02); send(0, lb);
            exp_run[lb[1:0]-1] = 1'b1;
            exp_sa[6*(lb[1:0]-1) +: 6] = lb[7:2];
            send(1, 8'h03); send(0, b);
            if (b[1:0] != 0) exp_run[b[1:0]-1] = 1'b0;
            chk($sformatf("R7 halt err %0h", v), bad_param, b[1:0] == 0);
            chk($sformatf("R7 run %0h", v), run, exp_run);
        end

        // R9: unknown opcode then data bytes
        send(1, 8'h02); send(0, 8'h06);
        exp_run[1] = 1'b1;
        send(1, 8'h00); send(0, 8'h01);
        chk("R9 no err", bad_param, 0);
        send(0, 8'h03);
        chk("R9 run unchanged", run, exp_run);
        rd(8'h06, d);
        chk("R9 mem unchanged", d, 16'h7700);

        // R8: end event
        send(1, 8'h02); send(0, 8'h05);
        @(negedge clk); eng_done = 3'b010;
        @(negedge clk); eng_done = 3'b000;
        chk("R8 end irq", end_irq, 3'b010);
        chk("R8 end stops run", run[1], 0);
        // R8: halt and end same cycle on engine 0
        send(1, 8'h02); send(0, 8'h09);
        send(1, 8'h03);
        @(negedge clk); byte_valid = 1; byte_data = 8'h01; eng_done = 3'b001;
        @(negedge clk); byte_valid = 0; eng_done = 3'b000;
        chk("R8 halt+end irq", end_irq, 3'b011);
        chk("R8 halt+end run", run[0], 0);
        // R8: ack with simultaneous end on engine 2
        @(negedge clk); irq_ack = 1; eng_done = 3'b100;
        @(negedge clk); irq_ack = 0; eng_done = 3'b000;
        chk("R8 ack vs set", end_irq, 3'b100);
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
        chk("R8 ack clears", end_irq, 3'b000);

        finish_run();
    end
endmodule